// File: doc/BRIEF.md
# NCO Baud Tick Generator

This block derives serial-line bit timing from the system clock with a numerically controlled oscillator. A 16-bit phase increment is added to a 16-bit phase accumulator on every clock. Each carry out of the accumulator produces a one-cycle oversample tick at sixteen times the bit rate. A prescaler counts sixteen of these ticks to mark each bit boundary. A character framer counts ten bit boundaries to mark the end of one character time.

The resulting bit rate is increment × f_clk / 2^20. The 2^16 accumulator range combined with the divide-by-16 prescaler gives that 2^20 scaling. The generator runs only while the run enable is high and the increment is non-zero. Otherwise it emits nothing and holds its accumulator and counters. A new increment is used from the next clock edge without clearing the accumulator, so reprogramming the rate does not produce a phase jump.

The character framer is a two-state machine over a bit counter:
- ST_COUNTING: collects bit ticks. It moves to ST_FINAL when the bit tick arrives that leaves exactly one bit of the character to go.
- ST_FINAL: waits for that last bit tick, then pulses the character-done output and returns to ST_COUNTING with the bit counter cleared.

Top module: `baud_nco_gen`

## Requirements
- R1: While reset is asserted, sample_tick, bit_tick and char_done are low. On release, the phase accumulator and all counters start from zero.
- R2: Starting from reset with the generator active for N clock edges at increment K, sample_tick pulses exactly floor(N·K / 65536) times. Each pulse is visible in the cycle after the edge whose addition carried out of bit 15.
- R3: bit_tick pulses once for every 16 sample_tick pulses, in the cycle after the 16th pulse, and never in two consecutive cycles.
- R4: char_done pulses once for every 10 bit_tick pulses, in the cycle after the 10th pulse, and never in two consecutive cycles.
- R5: While phase_inc is zero, no sample_tick is produced after the next edge, and the accumulator and counters keep their values. Observable behaviour: a later non-zero increment continues from the held phase.
- R6: While run_en is low, the generator behaves as in R5: no ticks, and the accumulator and counters are held.
- R7: A new phase_inc value is added at the very next clock edge, on top of the accumulator value left by the previous increment. The accumulator is not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Generator enable; low holds all state |
| phase_inc | input | 16 | Phase increment (upper half of the control word) |
| sample_tick | output | 1 | One-cycle pulse per accumulator carry (16× bit rate) |
| bit_tick | output | 1 | One-cycle pulse per bit period |
| char_done | output | 1 | One-cycle pulse per ten bit periods |

## Verification
The hardest state to reach from the ports is a half-built phase: an accumulator that has partly advanced and is then frozen, either by a zero increment or by a low enable. Only the timing of the first tick after resuming shows whether that phase was kept. The bench therefore advances the accumulator by a fraction of a wrap, freezes it for several cycles, and resumes with an increment that can carry only if the old phase was preserved. The same method, with a second, different increment, proves that an increment change takes effect immediately. A table of increment/duration pairs, including pairs one cycle either side of the 10th bit tick and of the first carry, checks the pulse counts of all three outputs against the floor formulas.

// File: rtl/baud_nco_pkg.sv
package baud_nco_pkg;

    typedef enum logic [0:0] {
        ST_COUNTING = 1'b0,
        ST_FINAL    = 1'b1
    } frame_state_t;

endpackage

// File: rtl/baud_nco_phase.sv
module baud_nco_phase #(
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic [PHASE_W-1:0] inc,
    output logic [PHASE_W-1:0] acc,
    output logic               carry_tick
);
    logic [PHASE_W-1:0] acc_q;
    logic               tick_q;
    logic [PHASE_W:0]   sum;

    always_comb begin
        sum = {1'b0, acc_q} + {1'b0, inc};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else if (active) begin
            acc_q  <= sum[PHASE_W-1:0];
            tick_q <= sum[PHASE_W];
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign acc        = acc_q;
    assign carry_tick = tick_q;
endmodule

// File: rtl/baud_nco_prescale.sv
module baud_nco_prescale #(
    parameter int RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_tick,
    output logic out_tick
);
    localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else begin
            out_q <= 1'b0;
            if (in_tick) begin
                if (cnt_q == LAST) begin
                    cnt_q <= '0;
                    out_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign out_tick = out_q;
endmodule

// File: rtl/baud_nco_framer.sv
module baud_nco_framer
    import baud_nco_pkg::*;
#(
    parameter int BITS_PER_CHAR = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic done
);
    localparam int CNT_W = $clog2(BITS_PER_CHAR);
    localparam logic [CNT_W-1:0] PENULT = CNT_W'(BITS_PER_CHAR - 2);

    frame_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_COUNTING: begin
                if (bit_in) begin
                    if (cnt_q == PENULT) begin
                        state_d = ST_FINAL;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_FINAL: begin
                if (bit_in) begin
                    state_d = ST_COUNTING;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_COUNTING;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNTING;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FINAL) && bit_in;
        end
    end

    assign done = done_q;
endmodule

// File: rtl/baud_nco_gen.sv
module baud_nco_gen #(
    parameter int PHASE_W       = 16,
    parameter int OS_RATIO      = 16,
    parameter int BITS_PER_CHAR = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic [PHASE_W-1:0] phase_inc,
    output logic               sample_tick,
    output logic               bit_tick,
    output logic               char_done
);
    logic               active;
    logic [PHASE_W-1:0] phase_acc;

    assign active = run_en && (phase_inc != '0);

    baud_nco_phase #(.PHASE_W(PHASE_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .inc        (phase_inc),
        .acc        (phase_acc),
        .carry_tick (sample_tick)
    );

    baud_nco_prescale #(.RATIO(OS_RATIO)) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_tick  (sample_tick),
        .out_tick (bit_tick)
    );

    baud_nco_framer #(.BITS_PER_CHAR(BITS_PER_CHAR)) u_framer (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_in (bit_tick),
        .done   (char_done)
    );
endmodule

// File: rtl/baud_nco_gen_chk.sv
module baud_nco_gen_chk #(
    parameter int PHASE_W  = 16,
    parameter int OS_RATIO = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run_en,
    input logic [PHASE_W-1:0] phase_inc,
    input logic [PHASE_W-1:0] phase_acc,
    input logic               sample_tick,
    input logic               bit_tick,
    input logic               char_done
);
    logic [$clog2(OS_RATIO+2)-1:0] os_since_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_since_bit <= '0;
        end else if (bit_tick) begin
            os_since_bit <= {{($bits(os_since_bit)-1){1'b0}}, sample_tick};
        end else if (sample_tick) begin
            os_since_bit <= os_since_bit + 1'b1;
        end
    end

    AST_BIT_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> $past(sample_tick)); // R3

    AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick); // R3

    AST_SAMPLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        os_since_bit <= ($bits(os_since_bit))'(OS_RATIO)); // R3

    AST_CHAR_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |-> $past(bit_tick)); // R4

    AST_CHAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> !char_done); // R4

    AST_ZERO_INC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_inc == '0) |=> (!sample_tick && $stable(phase_acc))); // R5

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!sample_tick && $stable(phase_acc))); // R6

    AST_ACC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && phase_inc != '0) |=> (phase_acc == PHASE_W'($past(phase_acc) + $past(phase_inc)))); // R7
endmodule

bind baud_nco_gen baud_nco_gen_chk #(.PHASE_W(PHASE_W), .OS_RATIO(OS_RATIO)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .phase_inc   (phase_inc),
    .phase_acc   (phase_acc),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick),
    .char_done   (char_done)
);

// File: tb/baud_nco_gen_bench.sv
module baud_nco_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [15:0] phase_inc = '0;
    logic        sample_tick, bit_tick, char_done;

    int total = 0;
    int bad = 0;
    int n_os = 0, n_bit = 0, n_chr = 0;
    bit counting = 1'b0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    baud_nco_gen u_baud_nco_gen (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .phase_inc(phase_inc),
        .sample_tick(sample_tick), .bit_tick(bit_tick), .char_done(char_done)
    );

    always @(negedge clk) begin
        if (counting) begin
            n_os  += int'(sample_tick);
            n_bit += int'(bit_tick);
            n_chr += int'(char_done);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // {increment, active edges, expected sample, bit, char ticks}
    localparam int NV = 8;
    localparam int VEC [NV][5] = '{
        '{32'hFFFF,  200, 199, 12, 1},
        '{32'h8000,  400, 200, 12, 1},
        '{32'h1000, 3300, 206, 12, 1},
        '{32'h4000,  640, 160, 10, 1},
        '{32'h4000,  636, 159,  9, 0},
        '{32'h0010, 4096,   1,  0, 0},
        '{32'h0010, 4095,   0,  0, 0},
        '{32'h2000, 1280, 160, 10, 1}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; run_en = 1'b0; phase_inc = '0; counting = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_os = 0; n_bit = 0; n_chr = 0;
    endtask

    task automatic run_vector(input int inc, input int n, input int e_os,
                              input int e_bit, input int e_chr);
        do_reset();
        phase_inc = inc[15:0];
        run_en = 1'b1;
        counting = 1'b1;
        repeat (n) @(negedge clk);
        run_en = 1'b0;
        phase_inc = '0;
        repeat (4) @(negedge clk);
        counting = 1'b0;
        check("R2 sample count", n_os, e_os);
        check("R3 bit count", n_bit, e_bit);
        check("R4 char count", n_chr, e_chr);
    endtask

    initial begin
        // R1: outputs low during reset
        repeat (2) @(negedge clk);
        check("R1 sample_tick in reset", int'(sample_tick), 0);
        check("R1 bit_tick in reset", int'(bit_tick), 0);
        check("R1 char_done in reset", int'(char_done), 0);

        for (int i = 0; i < NV; i++) begin
            run_vector(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
        end

        // R2: first carry timing with half-wrap increment
        do_reset();
        phase_inc = 16'h8000; run_en = 1'b1;
        @(negedge clk);
        check("R2 no carry after first add", int'(sample_tick), 0);
        @(negedge clk);
        check("R2 carry after second add", int'(sample_tick), 1);

        // R6: enable low freezes half-built phase
        do_reset();
        phase_inc = 16'h8000; run_en = 1'b1;
        @(negedge clk);
        run_en = 1'b0;
        counting = 1'b1;
        repeat (6) @(negedge clk);
        counting = 1'b0;
        check("R6 no ticks while disabled", n_os, 0);
        run_en = 1'b1;
        @(negedge clk);
        check("R6 phase kept across disable", int'(sample_tick), 1);

        // R5: zero increment freezes phase
        do_reset();
        phase_inc = 16'h8000; run_en = 1'b1;
        @(negedge clk);
        phase_inc = 16'h0000;
        counting = 1'b1;
        repeat (6) @(negedge clk);
        counting = 1'b0;
        check("R5 no ticks at zero increment", n_os, 0);
        phase_inc = 16'h8000;
        @(negedge clk);
        check("R5 phase kept across zero increment", int'(sample_tick), 1);

        // R7: new increment added next edge on retained phase
        do_reset();
        phase_inc = 16'hC000; run_en = 1'b1;
        @(negedge clk);
        check("R7 no carry from C000", int'(sample_tick), 0);
        phase_inc = 16'h4000;
        @(negedge clk);
        check("R7 carry from C000+4000", int'(sample_tick), 1);
        phase_inc = 16'h0001;
        @(negedge clk);
        check("R7 small increment no carry", int'(sample_tick), 0);
        run_en = 1'b0;

        // R1: reset mid-run clears state
        do_reset();
        phase_inc = 16'h8000; run_en = 1'b1;
        @(negedge clk);
        check("R1 accumulator zero after reset", int'(sample_tick), 0);
        run_en = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule